// File: doc/BRIEF.md
# I2C Slave Address and General-Call Decoder

This block sits behind an I2C byte deserialiser and inspects the opening bytes of each transfer. When a byte marked as the first of a transfer arrives, its upper seven bits are compared against four programmable slave identities. On a hit the block raises a one-cycle match strobe, reports which identity was hit as a binary index, and keeps the direction bit from the byte.

When general-call recognition is on, a first byte of all zeros is not treated as an ordinary address. It arms a classifier for the byte that follows. That second byte is sorted into one of three recognised classes:
- reset with address reprogramming
- address reprogramming only
- a hardware general call, whose byte is handed on to the receive FIFO

The block reports the class as a two-bit type and drives single-cycle action pulses. A reset class also returns the block's held match state to its reset values. Line handling, acknowledge generation and byte assembly are done elsewhere.

Top module: `i2c_addr_decoder`

## Requirements
- R1: A valid first byte whose bits 7:1 equal slave identity k drives `addr_match` high for exactly the one cycle after the byte's clock edge. In that same cycle `match_id` reads k, coded 0 to 3 for identities 0 to 3.
- R2: When several identities hold the matching address, `match_id` reports the lowest-numbered one.
- R3: On a match, `rw_dir` takes bit 0 of the first byte (1 = read). It holds that value until the next match or a general-call reset.
- R4: A first byte matching no identity produces no `addr_match` pulse.
- R5: With `gc_en` = 1, a first byte of 0x00 produces no `addr_match`, even when an identity holds address 0, and arms the general-call classifier. With `gc_en` = 0, 0x00 is matched like any other address.
- R6: An armed second byte of 0x06 drives `gc_strobe` and `prog_addr` for one cycle, and `gc_type` becomes 2'b01.
- R7: An armed second byte of 0x04 drives `gc_strobe` and `prog_addr` for one cycle, and `gc_type` becomes 2'b10.
- R8: An armed second byte with bit 0 set drives `gc_strobe` and `fwd_valid` for one cycle, with `fwd_data` equal to that byte. `gc_type` becomes 2'b11 and `prog_addr` stays low.
- R9: One cycle after a type 2'b01 `gc_strobe`, `reset_req` pulses for exactly one cycle. In that same cycle `match_id` and `rw_dir` read 0.
- R10: Only the byte directly after an armed 0x00 is classified. An even second byte other than 0x04 or 0x06 raises no strobe and leaves `gc_type` at 2'b00. Later non-first bytes raise no strobe and leave `gc_type` unchanged.
- R11: `gc_type` reads 2'b00 after reset and after every valid first byte. Otherwise it holds the last classification.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | An assembled byte is present this cycle |
| first_byte | input | 1 | The present byte is the first after a start condition |
| byte_data | input | 8 | Assembled byte |
| gc_en | input | 1 | Enables general-call recognition |
| slave_ids | input | 28 | Four 7-bit identities; identity k occupies bits 7k+6:7k |
| addr_match | output | 1 | One-cycle address-hit strobe |
| match_id | output | 2 | Index of the identity hit |
| rw_dir | output | 1 | Direction bit of the matched address byte |
| gc_strobe | output | 1 | One-cycle recognised general-call strobe |
| gc_type | output | 2 | General-call class: 00 none, 01 reset+program, 10 program, 11 hardware |
| reset_req | output | 1 | Reset request pulse |
| prog_addr | output | 1 | Program-address pulse |
| fwd_valid | output | 1 | Second byte of a hardware general call is offered to the receive FIFO |
| fwd_data | output | 8 | Byte offered with `fwd_valid` |

## Verification
The hardest case to reach is the general-call reset. It must arrive while a match from an earlier transfer still holds a non-zero index and a read direction, so that the clearing in the `reset_req` cycle can be seen at the ports. The stimulus therefore first addresses the highest identity with a read byte. It then sends 0x00 followed by 0x06 and samples the cycle of `gc_strobe` and the next one separately. The overlap between address 0 and the general-call address is reached by loading an identity with 0 and sending 0x00 with `gc_en` in both states.

// File: rtl/i2c_adec_pkg.sv
package i2c_adec_pkg;
   typedef enum logic [1:0] {
      GC_NONE     = 2'b00,
      GC_RST_PROG = 2'b01,
      GC_PROG     = 2'b10,
      GC_HW       = 2'b11
   } gc_kind_e;
endpackage

// File: rtl/i2c_adec_id_match.sv
module i2c_adec_id_match #(
   parameter int NUM_IDS = 4,
   parameter int ADDR_W  = 7,
   localparam int IDX_W  = $clog2(NUM_IDS)
) (
   input  logic [NUM_IDS*ADDR_W-1:0] ids,
   input  logic [ADDR_W-1:0]         addr,
   output logic                      hit,
   output logic [IDX_W-1:0]          idx
);
   if (NUM_IDS < 2) begin : g_bad_ids
      $error("NUM_IDS must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   logic [NUM_IDS-1:0] eq;

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_cmp
      assign eq[i] = (ids[i*ADDR_W +: ADDR_W] == addr);
   end

   // descending walk: the last assignment, lowest index, wins
   always_comb begin
      idx = '0;
      for (int i = NUM_IDS - 1; i >= 0; i--) begin
         if (eq[i]) idx = IDX_W'(i);
      end
   end

   assign hit = |eq;
endmodule

// File: rtl/i2c_adec_gc_class.sv
module i2c_adec_gc_class
   import i2c_adec_pkg::*;
#(
   parameter int         BYTE_W    = 8,
   parameter logic [7:0] RST_CODE  = 8'h06,
   parameter logic [7:0] PROG_CODE = 8'h04,
   parameter bit         HW_GC_EN  = 1'b1
) (
   input  logic [BYTE_W-1:0] data,
   output gc_kind_e          kind,
   output logic              known
);
   if (BYTE_W != 8) begin : g_bad_width
      $error("BYTE_W must be 8");
   end
   if (RST_CODE[0] || PROG_CODE[0]) begin : g_bad_codes
      $error("reset and program codes must be even");
   end

   logic hw_hit;

   if (HW_GC_EN) begin : g_hw_on
      assign hw_hit = data[0];
   end else begin : g_hw_off
      assign hw_hit = 1'b0;
   end

   always_comb begin
      if (hw_hit)                 kind = GC_HW;
      else if (data == RST_CODE)  kind = GC_RST_PROG;
      else if (data == PROG_CODE) kind = GC_PROG;
      else                        kind = GC_NONE;
      known = (kind != GC_NONE);
   end
endmodule

// File: rtl/i2c_addr_decoder.sv
module i2c_addr_decoder
   import i2c_adec_pkg::*;
#(
   parameter int         NUM_IDS   = 4,
   parameter int         BYTE_W    = 8,
   parameter logic [7:0] RST_CODE  = 8'h06,
   parameter logic [7:0] PROG_CODE = 8'h04,
   parameter bit         HW_GC_EN  = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 byte_valid,
   input  logic                                 first_byte,
   input  logic [BYTE_W-1:0]                    byte_data,
   input  logic                                 gc_en,
   input  logic [NUM_IDS*(BYTE_W-1)-1:0]        slave_ids,
   output logic                                 addr_match,
   output logic [$clog2(NUM_IDS)-1:0]           match_id,
   output logic                                 rw_dir,
   output logic                                 gc_strobe,
   output logic [1:0]                           gc_type,
   output logic                                 reset_req,
   output logic                                 prog_addr,
   output logic                                 fwd_valid,
   output logic [BYTE_W-1:0]                    fwd_data
);
   localparam int ADDR_W = BYTE_W - 1;
   localparam int IDX_W  = $clog2(NUM_IDS);

   if (NUM_IDS != 4) begin : g_bad_count
      $error("the two-bit identity code needs NUM_IDS == 4");
   end

   logic             id_hit;
   logic [IDX_W-1:0] id_idx;
   gc_kind_e         cls_kind;
   logic             cls_known;
   logic             gc_armed;
   logic             rst_pend;
   logic             is_gc_addr;

   i2c_adec_id_match #(.NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W)) u_match (
      .ids  (slave_ids),
      .addr (byte_data[BYTE_W-1:1]),
      .hit  (id_hit),
      .idx  (id_idx)
   );

   i2c_adec_gc_class #(
      .BYTE_W(BYTE_W), .RST_CODE(RST_CODE),
      .PROG_CODE(PROG_CODE), .HW_GC_EN(HW_GC_EN)
   ) u_class (
      .data  (byte_data),
      .kind  (cls_kind),
      .known (cls_known)
   );

   assign is_gc_addr = gc_en && (byte_data == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_match <= 1'b0;
         match_id   <= '0;
         rw_dir     <= 1'b0;
         gc_strobe  <= 1'b0;
         gc_type    <= GC_NONE;
         reset_req  <= 1'b0;
         prog_addr  <= 1'b0;
         fwd_valid  <= 1'b0;
         fwd_data   <= '0;
         gc_armed   <= 1'b0;
         rst_pend   <= 1'b0;
      end else begin
         addr_match <= 1'b0;
         gc_strobe  <= 1'b0;
         prog_addr  <= 1'b0;
         fwd_valid  <= 1'b0;
         reset_req  <= rst_pend;
         rst_pend   <= 1'b0;
         if (rst_pend) begin
            match_id <= '0;
            rw_dir   <= 1'b0;
         end
         if (byte_valid) begin
            if (first_byte) begin
               gc_type  <= GC_NONE;
               gc_armed <= is_gc_addr;
               if (!is_gc_addr && id_hit) begin
                  addr_match <= 1'b1;
                  match_id   <= id_idx;
                  rw_dir     <= byte_data[0];
               end
            end else if (gc_armed) begin
               gc_armed <= 1'b0;
               if (cls_known) begin
                  gc_strobe <= 1'b1;
                  gc_type   <= cls_kind;
                  prog_addr <= (cls_kind == GC_RST_PROG) || (cls_kind == GC_PROG);
                  rst_pend  <= (cls_kind == GC_RST_PROG);
                  if (cls_kind == GC_HW) begin
                     fwd_valid <= 1'b1;
                     fwd_data  <= byte_data;
                  end
               end
            end
         end
      end
   end

   // R1: a match strobe follows a valid first byte
   a_r1_match_after_first: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match |-> $past(byte_valid && first_byte));
   // R5: an address match and a general-call strobe never coincide
   a_r5_match_gc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_match, gc_strobe}));
   // R6, R7: a program pulse accompanies only a reprogramming class
   a_r7_prog_with_class: assert property (@(posedge clk) disable iff (!rst_n)
      prog_addr |-> gc_strobe && (gc_type == 2'b01 || gc_type == 2'b10));
   // R8: forwarding only for the hardware class
   a_r8_fwd_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> gc_strobe && gc_type == 2'b11 && fwd_data[0]);
   // R9: reset request trails a reset-class strobe by one cycle
   a_r9_reset_follows: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(gc_strobe) && $past(gc_type) == 2'b01);
   // R9: single-cycle reset request with cleared match state
   a_r9_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);
   a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req && !$past(byte_valid && first_byte) |-> match_id == '0 && !rw_dir);
   // R10: a strobe follows a non-first byte
   a_r10_gc_after_second: assert property (@(posedge clk) disable iff (!rst_n)
      gc_strobe |-> $past(byte_valid && !first_byte));
endmodule

// File: tb/i2c_addr_decoder_test.sv
`timescale 1ns/1ps
module i2c_addr_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_valid = 1'b0;
   logic        first_byte = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        gc_en = 1'b1;
   logic [27:0] slave_ids;
   logic        addr_match, rw_dir, gc_strobe, reset_req, prog_addr, fwd_valid;
   logic [1:0]  match_id, gc_type;
   logic [7:0]  fwd_data;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   i2c_addr_decoder uut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .first_byte(first_byte),
      .byte_data(byte_data), .gc_en(gc_en), .slave_ids(slave_ids),
      .addr_match(addr_match), .match_id(match_id), .rw_dir(rw_dir),
      .gc_strobe(gc_strobe), .gc_type(gc_type), .reset_req(reset_req),
      .prog_addr(prog_addr), .fwd_valid(fwd_valid), .fwd_data(fwd_data)
   );

   // {byte, expect match, expect id, expect rw}
   localparam logic [11:0] VEC [6] = '{
      {8'h42, 1'b1, 2'd0, 1'b0},
      {8'h43, 1'b1, 2'd0, 1'b1},
      {8'h6A, 1'b1, 2'd1, 1'b0},
      {8'hA1, 1'b1, 2'd3, 1'b1},
      {8'h44, 1'b0, 2'd0, 1'b0},
      {8'h6B, 1'b1, 2'd1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one byte across a rising edge; return at the following falling edge
   task automatic send(input logic first, input logic [7:0] b);
      @(negedge clk);
      byte_valid = 1'b1;
      first_byte = first;
      byte_data  = b;
      @(posedge clk);
      @(negedge clk);
      byte_valid = 1'b0;
      first_byte = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      chk("watchdog", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // id3=0x50, id2=0x35, id1=0x35, id0=0x21
      slave_ids = {7'h50, 7'h35, 7'h35, 7'h21};
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R12 reset outputs", {addr_match, match_id, rw_dir, gc_strobe, gc_type,
          reset_req, prog_addr, fwd_valid, fwd_data}, 0);
      rst_n = 1'b1;

      for (int i = 0; i < 6; i++) begin
         send(1'b1, VEC[i][11:4]);
         chk("R1 R4 match strobe", addr_match, VEC[i][3]);
         if (VEC[i][3]) begin
            chk("R1 R2 match id", match_id, VEC[i][2:1]);
            chk("R3 direction", rw_dir, VEC[i][0]);
         end
         @(negedge clk);
         chk("R1 strobe single cycle", addr_match, 0);
      end

      // R9: load a non-zero match, then general-call reset
      send(1'b1, 8'hA1);
      chk("R3 held before reset", {match_id, rw_dir}, 3'b111);
      send(1'b1, 8'h00);
      chk("R5 gc address no match", addr_match, 0);
      chk("R11 type after first", gc_type, 0);
      send(1'b0, 8'h06);
      chk("R6 strobe", gc_strobe, 1);
      chk("R6 type", gc_type, 2'b01);
      chk("R6 prog pulse", prog_addr, 1);
      chk("R9 no early reset", reset_req, 0);
      @(negedge clk);
      chk("R9 reset pulse", reset_req, 1);
      chk("R9 cleared state", {match_id, rw_dir}, 0);
      chk("R6 strobe single", {gc_strobe, prog_addr}, 0);
      @(negedge clk);
      chk("R9 reset single", reset_req, 0);

      send(1'b1, 8'h00);
      send(1'b0, 8'h04);
      chk("R7 strobe type prog", {gc_strobe, gc_type, prog_addr, fwd_valid}, 5'b1_10_1_0);
      @(negedge clk);
      chk("R7 no reset request", reset_req, 0);

      send(1'b1, 8'h00);
      send(1'b0, 8'h0B);
      chk("R8 strobe type fwd", {gc_strobe, gc_type, prog_addr, fwd_valid}, 5'b1_11_0_1);
      chk("R8 forwarded byte", fwd_data, 8'h0B);
      send(1'b0, 8'h06);
      chk("R10 third byte ignored", {gc_strobe, prog_addr, fwd_valid}, 0);
      chk("R10 type held", gc_type, 2'b11);
      send(1'b1, 8'h44);
      chk("R11 type cleared by first", gc_type, 0);

      send(1'b1, 8'h00);
      send(1'b0, 8'h02);
      chk("R10 unknown even code", {gc_strobe, gc_type, prog_addr}, 0);

      // R5: identity 0 at address 0
      slave_ids = {7'h50, 7'h35, 7'h35, 7'h00};
      send(1'b1, 8'h00);
      chk("R5 gc enabled hides id0", addr_match, 0);
      gc_en = 1'b0;
      send(1'b1, 8'h00);
      chk("R5 gc disabled matches id0", {addr_match, match_id}, 3'b1_00);
      send(1'b0, 8'h06);
      chk("R5 not armed when disabled", gc_strobe, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule